// File: doc/BRIEF.md
# Register-Controlled Even Clock Divider

This block derives a slower clock from its source clock by an even factor between 2 and 16, always with equal high and low times. One 32-bit control word, reached through a small synchronous register port, holds a run flag and a ratio code. The divided clock is a register output in the source domain, so it has no combinational glitches. It also runs straight out of reset, because downstream logic depends on it.

A small state machine drives the output. Its states are `ST_PARK` (stopped, output low), `ST_LOW` (low half-period) and `ST_HIGH` (high half-period). Its transitions are:
- `T_START`: `ST_PARK` to `ST_LOW`, when the run flag is set.
- `T_RISE`: `ST_LOW` to `ST_HIGH`, at the end of a low half. The ratio is sampled here.
- `T_FALL`: `ST_HIGH` to `ST_LOW`, at the end of a high half while running.
- `T_STOP_HIGH`: `ST_HIGH` to `ST_PARK`, at the end of a high half when the run flag is clear.
- `T_STOP_LOW`: `ST_LOW` to `ST_PARK`, at once when the run flag is clear.

A half-period counter reloads on every transition. The ratio in use is latched at `T_START` and `T_RISE`. Software is expected to leave the run flag set in normal operation.

Control word layout: bit 15 is the run flag and bits 4:0 are the ratio code. Code c selects division by 2*(c+1).

Top module: `even_clkdiv`

## Requirements
- R1: After reset the control word reads 0x0000_8003 and the output runs with high and low phases of 4 source cycles each. While reset is asserted, `div_clk` is 0.
- R2: Bits 31:16 and 14:5 of the control word always read 0. Data written to them has no effect.
- R3: With ratio code c (0 to 7) and the run flag set, the output is high for c+1 cycles and low for c+1 cycles.
- R4: A write whose bits 4:0 exceed 7 leaves the ratio code unchanged. The run flag (bit 15) of the same write is still applied.
- R5: A new ratio takes effect only at the next rising output edge. A low phase already under way finishes with the old length.
- R6: Clearing the run flag lets the current high phase finish at full length. The output then stays low.
- R7: Setting the run flag again restarts the output after a low phase. The first high phase has full length.
- R8: The register responds only at address `REG_ADDR` (0x60). Writes elsewhere are ignored, and reads elsewhere return 0.
- R9: Read data is registered with one cycle of latency. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| div_clk | output | 1 | Divided clock |

## Verification
A register write and a register read can land in the same cycle. The bench provokes this by holding the address on the control word while strobing a write. It then expects the old word one cycle later and the new word the cycle after that.

A ratio write and an output phase in progress also overlap. The bench issues the write inside a high phase and checks two things: the following low phase keeps the old length, and only the high phase after the next rising edge uses the new one.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } div_state_e;

endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs #(
    parameter int                  ADDR_W    = 8,
    parameter int                  DATA_W    = 32,
    parameter logic [ADDR_W-1:0]   REG_ADDR  = 8'h60,
    parameter int                  EN_BIT    = 15,
    parameter int                  CODE_W    = 5,
    parameter int                  MAX_CODE  = 7,
    parameter int                  RATIO_W   = 3,
    parameter int                  RST_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               ctl_en,
    output logic [RATIO_W-1:0] ctl_ratio
);

    localparam logic [CODE_W-1:0] MAX_CODE_V = CODE_W'(MAX_CODE);

    logic              hit;
    logic              code_ok;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wbits;

    assign hit          = (bus_addr == REG_ADDR);
    assign code_ok      = (bus_wdata[CODE_W-1:0] <= MAX_CODE_V);
    assign unused_wbits = ^{bus_wdata[DATA_W-1:EN_BIT+1], bus_wdata[EN_BIT-1:CODE_W]};

    // control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b1;
            ctl_ratio <= RATIO_W'(RST_RATIO);
        end else if (hit && bus_we) begin
            ctl_en <= bus_wdata[EN_BIT];
            if (code_ok) begin
                ctl_ratio <= bus_wdata[RATIO_W-1:0];
            end
        end
    end

    // read word: only defined fields are non-zero
    always_comb begin
        rd_word                = '0;
        rd_word[EN_BIT]        = ctl_en;
        rd_word[RATIO_W-1:0]   = ctl_ratio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= hit ? rd_word : '0;
        end
    end

endmodule

// File: rtl/ckdiv_fsm.sv
module ckdiv_fsm
    import ckdiv_pkg::*;
#(
    parameter int RATIO_W   = 3,
    parameter int RST_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic               div_clk
);

    div_state_e         state_q, state_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] act_q, act_n;
    logic               half_done;

    assign half_done = (cnt_q == act_q);

    // next-state and counter logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        act_n   = act_q;
        unique case (state_q)
            ST_PARK: begin
                if (run_en) begin                 // T_START
                    state_n = ST_LOW;
                    cnt_n   = '0;
                    act_n   = ratio_sel;
                end
            end
            ST_LOW: begin
                if (!run_en) begin                // T_STOP_LOW
                    state_n = ST_PARK;
                    cnt_n   = '0;
                end else if (half_done) begin     // T_RISE
                    state_n = ST_HIGH;
                    cnt_n   = '0;
                    act_n   = ratio_sel;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_HIGH: begin
                if (half_done) begin
                    cnt_n   = '0;
                    state_n = run_en ? ST_LOW : ST_PARK; // T_FALL / T_STOP_HIGH
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                state_n = ST_PARK;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
            act_q   <= RATIO_W'(RST_RATIO);
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            act_q   <= act_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_clk <= 1'b0;
        end else begin
            div_clk <= (state_n == ST_HIGH);
        end
    end

endmodule

// File: rtl/even_clkdiv.sv
module even_clkdiv #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h60,
    parameter int                EN_BIT   = 15,
    parameter int                CODE_W   = 5,
    parameter int                MAX_CODE = 7,
    parameter int                RST_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              div_clk
);

    localparam int RATIO_W = $clog2(MAX_CODE + 1);

    logic               ctl_en;
    logic [RATIO_W-1:0] ctl_ratio;

    ckdiv_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_ADDR  (REG_ADDR),
        .EN_BIT    (EN_BIT),
        .CODE_W    (CODE_W),
        .MAX_CODE  (MAX_CODE),
        .RATIO_W   (RATIO_W),
        .RST_RATIO (RST_CODE)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctl_en    (ctl_en),
        .ctl_ratio (ctl_ratio)
    );

    ckdiv_fsm #(
        .RATIO_W   (RATIO_W),
        .RST_RATIO (RST_CODE)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (ctl_en),
        .ratio_sel (ctl_ratio),
        .div_clk   (div_clk)
    );

endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h60,
    parameter int                EN_BIT   = 15,
    parameter int                CODE_W   = 5,
    parameter int                MAX_CODE = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              div_clk
);

    localparam int                RUN_W  = $clog2(MAX_CODE + 2) + 2;
    localparam logic [DATA_W-1:0] KEEP_M = DATA_W'((64'd1 << EN_BIT) | ((64'd1 << CODE_W) - 1));

    logic [RUN_W-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (div_clk) begin
            hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~KEEP_M) == '0);

    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[CODE_W-1:0] <= CODE_W'(MAX_CODE));

    p_high_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RUN_W'(MAX_CODE + 1));

    p_other_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |=> (bus_rdata == '0));

endmodule

bind even_clkdiv ckdiv_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR),
    .EN_BIT   (EN_BIT),
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .div_clk   (div_clk)
);

// File: tb/test_even_clkdiv.sv
`timescale 1ns/1ps
module test_even_clkdiv;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] REG_A      = 8'h60;
    localparam int         NV         = 10;

    localparam logic [31:0] V_WR [NV] = '{
        32'h0000_8000, 32'h0000_8001, 32'h0000_8009, 32'h0000_8002, 32'hFFFF_FFE5,
        32'h0000_8004, 32'h0000_801F, 32'h0000_8006, 32'h0000_8007, 32'h0000_8003};
    localparam logic [31:0] V_RD [NV] = '{
        32'h0000_8000, 32'h0000_8001, 32'h0000_8001, 32'h0000_8002, 32'h0000_8005,
        32'h0000_8004, 32'h0000_8004, 32'h0000_8006, 32'h0000_8007, 32'h0000_8003};
    localparam int V_HALF [NV] = '{1, 2, 2, 3, 6, 5, 5, 7, 8, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        div_clk;

    int n_chk = 0;
    int n_bad = 0;
    int rises = 0, falls = 0, hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
    logic prev = 1'b0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    even_clkdiv i_even_clkdiv (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_clk(div_clk));

    // phase-length monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            prev = 1'b0; hi_cnt = 0; lo_cnt = 0;
        end else if (div_clk && !prev) begin
            rises++; last_lo = lo_cnt; lo_cnt = 0; hi_cnt = 1;
        end else if (div_clk) begin
            hi_cnt++;
        end else if (prev) begin
            falls++; last_hi = hi_cnt; hi_cnt = 0; lo_cnt = 1;
        end else begin
            lo_cnt++;
        end
        if (rst_n) prev = div_clk;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step();
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        step();
        bus_addr = a;
        step();
        d = bus_rdata;
    endtask

    task automatic wait_rises(input int n);
        int tgt = rises + n;
        while (rises < tgt) step();
    endtask

    task automatic wait_falls(input int n);
        int tgt = falls + n;
        while (falls < tgt) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        check("R1 clk in reset", {31'd0, div_clk}, 32'd0);
        check("R1 rdata in reset", bus_rdata, 32'd0);
        step(); rst_n = 1'b1;
        rd(REG_A, rv);
        check("R1 reset word", rv, 32'h0000_8003);
        wait_rises(3);
        check("R1 low phase", last_lo, 4);
        wait_falls(1);
        check("R1 high phase", last_hi, 4);

        // R2/R3/R4: vector table
        for (int i = 0; i < NV; i++) begin
            wr(REG_A, V_WR[i]);
            rd(REG_A, rv);
            check("R2 R4 readback", rv, V_RD[i]);
            wait_rises(3);
            check("R3 low len", last_lo, V_HALF[i]);
            wait_falls(1);
            check("R3 high len", last_hi, V_HALF[i]);
        end

        // R5: ratio change only at the next rising edge
        wr(REG_A, 32'h0000_8007);
        wait_rises(3);
        wait_rises(1);
        wr(REG_A, 32'h0000_8000);
        wait_rises(1);
        check("R5 old low kept", last_lo, 8);
        wait_falls(1);
        check("R5 new high", last_hi, 1);
        wait_rises(1);
        check("R5 new low", last_lo, 1);

        // R6 + R4: stop with reserved code in the same write
        wr(REG_A, 32'h0000_8007);
        wait_rises(3);
        wait_rises(1);
        wr(REG_A, 32'h0000_0011);
        wait_falls(1);
        check("R6 final high full", last_hi, 8);
        begin
            int highs = 0;
            for (int k = 0; k < 40; k++) begin
                step();
                if (div_clk) highs++;
            end
            check("R6 parked low", highs, 0);
        end
        rd(REG_A, rv);
        check("R4 en applied code kept", rv, 32'h0000_0007);

        // R7: restart
        wr(REG_A, 32'h0000_8001);
        wait_rises(1);
        wait_falls(1);
        check("R7 first high full", last_hi, 2);
        wait_rises(1);
        check("R7 low after restart", last_lo, 2);

        // R8: other addresses
        wr(8'h64, 32'h0000_8005);
        rd(REG_A, rv);
        check("R8 write elsewhere ignored", rv, 32'h0000_8001);
        rd(8'h64, rv);
        check("R8 read elsewhere zero", rv, 32'h0);

        // R9: read and write in the same cycle
        step();
        bus_addr = REG_A; bus_we = 1'b1; bus_wdata = 32'h0000_8003;
        step();
        bus_we = 1'b0;
        check("R9 old value same cycle", bus_rdata, 32'h0000_8001);
        step();
        check("R9 new value next cycle", bus_rdata, 32'h0000_8003);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule